// File: doc/BRIEF.md
# Stereo Audio Serial Port (codec side)

This block is the digital serial port of an audio codec. It sits on a frame clock that marks left and right half-frames and on a bit clock that carries one data slot per period. It sends a pair of captured 16-bit samples out on a serial output line. It also collects a pair of playback samples from a serial input line and presents them as parallel words. The two directions use different alignment. Outgoing words start at the opening of each half-frame. Incoming words end on the last slot of each half-frame.

The frame clock, bit clock and serial input are sampled by the block's own system clock. They must already be synchronous to it, and each bit-clock phase must last at least two system-clock cycles. Bit-clock edges are found by comparing each sample with the one before. The port accepts 16 or 32 bit-clock periods per half-frame without any configuration. It reports which of the two rates the last half-frame used.

Top module: `audio_serial_port`

## Requirements
- R1: Samples are 16-bit two's complement words, sent and received most significant bit first.
- R2: On the bit-clock falling edge where the frame clock has changed level, the serial output is driven with bit 15 of the new channel's word. Each later falling edge drives the next lower bit.
- R3: The half-frame with the frame clock high carries the left channel, and it comes first in each frame. The half-frame with the frame clock low carries the right channel.
- R4: The serial output changes only after a detected bit-clock falling edge. The serial input is sampled only on bit-clock rising edges.
- R5: Once all 16 bits of a word have been sent, the serial output is held low for the rest of that half-frame.
- R6: Playback words are LSB-justified. The last 16 input slots of a half-frame form the word, with bit 0 in the final slot. Any earlier slots have no effect on the word.
- R7: Half-frames of 16 slots (32 bit clocks per frame) and of 32 slots (64 per frame) both work, and the rate may change between frames.
- R8: `frameIs64` is 1 when the most recently completed half-frame held more than 16 slots, and 0 otherwise. It changes only at a half-frame boundary.
- R9: `playValid` is high for exactly one system-clock cycle, on the cycle after the rising bit-clock edge that first sees the frame clock high again. `playLeft` and `playRight` change only in that cycle and hold their values otherwise.
- R10: Both capture inputs are latched when a left half-frame opens. Changes to them during the frame do not alter the words sent in that frame.
- R11: While reset is held and right after it is released, `sdtoOut`, `playValid`, `playLeft`, `playRight` and `frameIs64` are all 0.
- R12: No playback pair is issued until one full left half-frame and the right half-frame after it have been received since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every port input |
| rstN | input | 1 | Active-low synchronous reset |
| sclkIn | input | 1 | Serial bit clock, synchronous to clk |
| lrckIn | input | 1 | Frame clock: high for the left half, low for the right half |
| sdtiIn | input | 1 | Serial playback data |
| capLeft | input | 16 | Left capture sample to be sent |
| capRight | input | 16 | Right capture sample to be sent |
| sdtoOut | output | 1 | Serial capture data |
| playLeft | output | 16 | Last received left playback sample |
| playRight | output | 16 | Last received right playback sample |
| playValid | output | 1 | One-cycle strobe when a new playback pair is ready |
| frameIs64 | output | 1 | Rate of the previous half-frame: 1 for 32 slots, 0 for 16 |

## Verification
The bench runs frames at both rates, switches the rate in both directions, and puts alternating junk bits in the first 16 input slots of each wide half-frame. A port that took the MSB-justified window there, or that sampled from the first slot, would produce the wrong playback words. In every wide half-frame the bench also checks that the output stays low in the 16 slots after the word. A design that kept shifting would put stale bits there. The right capture input is changed partway through the left half, so a port that read it late would send the wrong right word. The bench also watches for a strobe during the first frame after reset and for a strobe that lasts more than one cycle. A design that issued a half-built pair or a stretched pulse would cause an extra pop from the expected queue, or a check on the pulse length would fail.

// File: rtl/asp_pkg.sv
package asp_pkg;

  // Strobes from the control section to the datapath, one system-clock cycle each
  typedef struct packed {
    logic txLoad;       // falling edge that opens a half-frame: load a new word
    logic txLeft;       // the word loaded belongs to the left channel
    logic txStep;       // any other falling edge: advance the serial output
    logic rxShift;      // rising edge: take one input bit
    logic rxTakeLeft;   // the left half has just ended: hold its word
    logic rxTakeRight;  // the right half has just ended: publish the pair
  } aspStrobe_t;

endpackage

// File: rtl/asp_ctrl.sv
module asp_ctrl
  import asp_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkIn,
  input  logic       lrckIn,
  output aspStrobe_t strobe,
  output logic       frameIs64
);

  localparam int SLOT_MAX = 2 * SAMPLE_W;
  localparam int CNT_W    = $clog2(SLOT_MAX) + 1;
  localparam logic [CNT_W-1:0] WIDE_AT = CNT_W'(SAMPLE_W);

  logic             sclkQ;
  logic             lrckCur;     // frame-clock level of the half-frame in progress
  logic [CNT_W-1:0] slotCnt;     // index of the current slot in the half-frame
  logic             seenEdge;
  logic             leftGood;
  logic             wideQ;

  logic sclkRise, sclkFall, lrckMoved, halfEdge;

  always_comb begin
    sclkRise  = sclkIn & ~sclkQ;
    sclkFall  = ~sclkIn & sclkQ;
    lrckMoved = (lrckIn != lrckCur);
    halfEdge  = sclkRise & lrckMoved;

    strobe.txLoad      = sclkFall & lrckMoved;
    strobe.txLeft      = lrckIn;
    strobe.txStep      = sclkFall & ~lrckMoved;
    strobe.rxShift     = sclkRise;
    strobe.rxTakeLeft  = halfEdge & ~lrckIn & seenEdge;
    strobe.rxTakeRight = halfEdge & lrckIn & leftGood;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ    <= 1'b0;
      lrckCur  <= 1'b0;
      slotCnt  <= '0;
      seenEdge <= 1'b0;
      leftGood <= 1'b0;
      wideQ    <= 1'b0;
    end else begin
      sclkQ <= sclkIn;
      if (sclkRise) begin
        if (lrckMoved) begin
          lrckCur  <= lrckIn;
          slotCnt  <= '0;
          seenEdge <= 1'b1;
          if (seenEdge) wideQ <= (slotCnt >= WIDE_AT);
          if (strobe.rxTakeLeft) leftGood <= 1'b1;
        end else if (slotCnt != '1) begin
          slotCnt <= slotCnt + 1'b1;
        end
      end
    end
  end

  assign frameIs64 = wideQ;

  // R8: the rate flag moves only at a half-frame boundary
  assert_width_on_edge_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(frameIs64) |-> $past(halfEdge));

  // R4: output advance strobes follow a high-to-low move of the bit clock
  assert_tx_on_fall_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.txLoad || strobe.txStep) |-> (!sclkIn && $past(sclkIn)));

endmodule

// File: rtl/asp_datapath.sv
module asp_datapath
  import asp_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  aspStrobe_t          strobe,
  input  logic                sdtiIn,
  input  logic [SAMPLE_W-1:0] capLeft,
  input  logic [SAMPLE_W-1:0] capRight,
  output logic                sdtoOut,
  output logic [SAMPLE_W-1:0] playLeft,
  output logic [SAMPLE_W-1:0] playRight,
  output logic                playValid
);

  localparam int TXC_W = $clog2(SAMPLE_W) + 1;
  localparam logic [TXC_W-1:0] TX_DONE = TXC_W'(SAMPLE_W);

  logic [SAMPLE_W-1:0] capHoldR;   // right capture word frozen at the left opening
  logic [SAMPLE_W-1:0] txWord;
  logic [TXC_W-1:0]    txCnt;
  logic                sdtoQ;
  logic [SAMPLE_W-1:0] rxWord;
  logic [SAMPLE_W-1:0] leftHold;
  logic [SAMPLE_W-1:0] playLQ, playRQ;
  logic                validQ;
  logic [SAMPLE_W-1:0] txSrc;

  always_comb txSrc = strobe.txLeft ? capLeft : capHoldR;

  // Capture direction: MSB-justified, then low
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capHoldR <= '0;
      txWord   <= '0;
      txCnt    <= TX_DONE;
      sdtoQ    <= 1'b0;
    end else if (strobe.txLoad) begin
      if (strobe.txLeft) capHoldR <= capRight;
      sdtoQ  <= txSrc[SAMPLE_W-1];
      txWord <= {txSrc[SAMPLE_W-2:0], 1'b0};
      txCnt  <= TXC_W'(1);
    end else if (strobe.txStep) begin
      if (txCnt < TX_DONE) begin
        sdtoQ  <= txWord[SAMPLE_W-1];
        txWord <= {txWord[SAMPLE_W-2:0], 1'b0};
        txCnt  <= txCnt + 1'b1;
      end else begin
        sdtoQ <= 1'b0;
      end
    end
  end

  // Playback direction: the newest 16 bits always sit in rxWord
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxWord   <= '0;
      leftHold <= '0;
      playLQ   <= '0;
      playRQ   <= '0;
      validQ   <= 1'b0;
    end else begin
      if (strobe.rxShift)    rxWord   <= {rxWord[SAMPLE_W-2:0], sdtiIn};
      if (strobe.rxTakeLeft) leftHold <= rxWord;
      validQ <= strobe.rxTakeRight;
      if (strobe.rxTakeRight) begin
        playLQ <= leftHold;
        playRQ <= rxWord;
      end
    end
  end

  assign sdtoOut   = sdtoQ;
  assign playLeft  = playLQ;
  assign playRight = playRQ;
  assign playValid = validQ;

  assert_tail_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.txStep && txCnt == TX_DONE) |=> !sdtoOut);

  assert_sdto_moves_on_fall_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdtoOut) |-> $past(strobe.txLoad || strobe.txStep));

  assert_left_msb_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.txLoad && strobe.txLeft) |=> (sdtoOut == $past(capLeft[SAMPLE_W-1])));

  assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    playValid |=> !playValid);

  assert_play_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(playLeft) || !$stable(playRight)) |-> playValid);

endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port
  import asp_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclkIn,
  input  logic                lrckIn,
  input  logic                sdtiIn,
  input  logic [SAMPLE_W-1:0] capLeft,
  input  logic [SAMPLE_W-1:0] capRight,
  output logic                sdtoOut,
  output logic [SAMPLE_W-1:0] playLeft,
  output logic [SAMPLE_W-1:0] playRight,
  output logic                playValid,
  output logic                frameIs64
);

  aspStrobe_t strobe;

  asp_ctrl #(.SAMPLE_W(SAMPLE_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclkIn    (sclkIn),
    .lrckIn    (lrckIn),
    .strobe    (strobe),
    .frameIs64 (frameIs64)
  );

  asp_datapath #(.SAMPLE_W(SAMPLE_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .sdtiIn    (sdtiIn),
    .capLeft   (capLeft),
    .capRight  (capRight),
    .sdtoOut   (sdtoOut),
    .playLeft  (playLeft),
    .playRight (playRight),
    .playValid (playValid)
  );

endmodule

// File: tb/sim_audio_serial_port.sv
`timescale 1ns/1ps
module sim_audio_serial_port;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclkIn = 1'b1;
  logic        lrckIn = 1'b0;
  logic        sdtiIn = 1'b0;
  logic [15:0] capLeft = '0;
  logic [15:0] capRight = '0;
  logic        sdtoOut;
  logic [15:0] playLeft, playRight;
  logic        playValid;
  logic        frameIs64;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [31:0] playQ[$];

  always #4 clk = ~clk;

  audio_serial_port u0 (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .lrckIn(lrckIn), .sdtiIn(sdtiIn),
    .capLeft(capLeft), .capRight(capRight), .sdtoOut(sdtoOut),
    .playLeft(playLeft), .playRight(playRight), .playValid(playValid),
    .frameIs64(frameIs64)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Monitor: pops expected playback pairs as the strobe appears (R9, R12, R6)
  logic prevValid = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (playValid && prevValid) check("R9 strobe longer than one cycle", 32'd1, 32'd0);
      if (playValid) begin
        if (playQ.size() == 0) check("R12 pair issued with nothing expected", 32'd1, 32'd0);
        else begin
          logic [31:0] e;
          e = playQ.pop_front();
          check("R6 R3 playback pair", {playLeft, playRight}, e);
        end
      end
      prevValid <= playValid;
    end
  end

  // Driver: one frame; half 0 is left (frame clock high), half 1 is right
  task automatic runFrame(input int slots, input logic [15:0] pL, input logic [15:0] pR,
                          input logic [15:0] cL, input logic [15:0] cR);
    capLeft  = cL;
    capRight = cR;
    for (int h = 0; h < 2; h++) begin
      logic [15:0] inWord, outWord, expOut;
      logic tailBad;
      inWord  = (h == 0) ? pL : pR;
      expOut  = (h == 0) ? cL : cR;
      outWord = '0;
      tailBad = 1'b0;
      for (int s = 0; s < slots; s++) begin
        @(negedge clk);
        sclkIn = 1'b0;
        if (s == 0) lrckIn = (h == 0);
        if (s >= slots - 16) sdtiIn = inWord[slots - 1 - s];
        else sdtiIn = s[0] ^ h[0] ^ 1'b1;   // junk in the ignored slots (R6)
        if (h == 0 && s == 5) capRight = ~cR; // late change must not reach the wire (R10)
        repeat (4) @(negedge clk);
        if (s < 16) outWord[15 - s] = sdtoOut;
        else if (sdtoOut !== 1'b0) tailBad = 1'b1;
        sclkIn = 1'b1;
        repeat (3) @(negedge clk);
      end
      check((h == 0) ? "R1 R2 R3 left capture word" : "R1 R2 R10 right capture word",
            {16'h0, outWord}, {16'h0, expOut});
      if (slots > 16) check("R5 output low after word", {31'h0, tailBad}, 32'd0);
    end
    playQ.push_back({pL, pR});
    check((slots > 16) ? "R8 R7 rate flag wide" : "R8 R7 rate flag narrow",
          {31'h0, frameIs64}, {31'h0, (slots > 16)});
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check("R11 sdto in reset", {31'h0, sdtoOut}, 32'd0);
    check("R11 valid in reset", {31'h0, playValid}, 32'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 outputs after reset", {playLeft, playRight}, 32'd0);
    check("R11 rate flag after reset", {31'h0, frameIs64}, 32'd0);
    check("R11 sdto after reset", {31'h0, sdtoOut}, 32'd0);

    runFrame(16, 16'h8001, 16'h7FFE, 16'hA5C3, 16'h0001);
    runFrame(16, 16'h0000, 16'hFFFF, 16'h8000, 16'h7FFF);
    runFrame(32, 16'h1234, 16'hFEDC, 16'h55AA, 16'hC33C);
    runFrame(32, 16'h8000, 16'h7FFF, 16'hFFFF, 16'h0000);
    runFrame(32, 16'h0F0F, 16'hF0F0, 16'h0001, 16'h8000);
    runFrame(16, 16'hBEEF, 16'h1357, 16'h2468, 16'hDEAD);
    runFrame(32, 16'h0001, 16'h8000, 16'h7FFE, 16'h4001);

    // Open one more left half so the last pair is published (R9)
    @(negedge clk); sclkIn = 1'b0; lrckIn = 1'b1;
    repeat (4) @(negedge clk); sclkIn = 1'b1;
    repeat (6) @(negedge clk);
    check("R9 all expected pairs issued", playQ.size(), 32'd0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog R9 got=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule